// File: doc/BRIEF.md
# Four-Mode Program Bank Translator

This block sits between a CPU address bus and two external memories: a program ROM and a work RAM. It turns every CPU access in the range 0x6000–0xFFFF into a flat address and picks which of the two memories answers. Its configuration is held in eight write-only registers in the 0x5100 page. A mode register divides the upper 32 KB into one, two, three or four windows. Every switchable window has its own bank number and its own ROM/RAM choice. The last window always comes from ROM.

Writes into work RAM that is banked into the upper 32 KB pass only while two key registers hold fixed unlock values. The low 8 KB RAM window at 0x6000 is always writable. The block is purely combinational from its address to its outputs, so a memory sees its new address in the same cycle the CPU drives it. Only the configuration registers are clocked.

Top module: `prg_bank_xlate`

## Requirements
- R1: After reset every configuration register is zero. Mode 0 is in force: 0x8000–0xFFFF maps to ROM flat address 0x0000–0x7FFF, 0x6000–0x7FFF maps to RAM page 0, and protection is locked.
- R2: A write to 0x5100 sets the mode from data bits 1:0. All other data bits are ignored.
- R3: 0x6000–0x7FFF always selects RAM at (0x5113 bits 2:0)·0x2000 + (address mod 0x2000). A write there always asserts `mem_we`, whatever the key registers hold.
- R4: In mode 0, 0x8000–0xFFFF selects ROM at (bank_last>>2)·0x8000 + (address mod 0x8000). bank_last is bits 6:0 of the last write to 0x5117.
- R5: In mode 1, 0x8000–0xBFFF uses (bank of 0x5115 >> 1)·0x4000 + (address mod 0x4000), in ROM or RAM as that register selects. 0xC000–0xFFFF selects ROM at (bank_last>>1)·0x4000 + (address mod 0x4000).
- R6: In mode 2, 0x8000–0xBFFF behaves as in mode 1. 0xC000–0xDFFF uses the bank of 0x5116 ·0x2000 + (address mod 0x2000) in ROM or RAM. 0xE000–0xFFFF selects ROM at bank_last·0x2000 + (address mod 0x2000).
- R7: In mode 3, the 8 KB windows at 0x8000, 0xA000 and 0xC000 use 0x5114, 0x5115 and 0x5116, each in ROM or RAM. 0xE000 uses bank_last in ROM. Each flat address is bank·0x2000 + (address mod 0x2000).
- R8: In registers 0x5114–0x5116, data bit 7 = 1 selects ROM for the window and bit 7 = 0 selects RAM. Bits 6:0 are the bank number.
- R9: Protection is released only while the last byte written to 0x5102 was 0x02 and the last byte written to 0x5103 was 0x01. Otherwise no write at 0x8000 or above asserts `mem_we`.
- R10: A write to a window mapped to ROM, including any write at 0x8000 or above in mode 0, never asserts `mem_we`.
- R11: When `cpu_we` is low, `mem_we` is low. Below 0x6000, `sel_ram`, `mem_we`, `rom_addr` and `ram_addr` are all zero.
- R12: `rom_addr` carries the full flat address (20 bits). `ram_addr` carries its low RAM_AW bits (16 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe; register writes take effect at the rising edge |
| sel_ram | output | 1 | 1 = work RAM answers, 0 = ROM |
| rom_addr | output | 20 | Flat ROM address |
| ram_addr | output | RAM_AW | Flat work-RAM address |
| mem_we | output | 1 | Write enable towards work RAM |

## Verification
The assertions check on every cycle the fixed facts of the map:
- `mem_we` is never asserted without `sel_ram`;
- a read never writes;
- the 0x6000 window is always RAM and 0xE000–0xFFFF is always ROM;
- mode 0 never selects RAM in the upper half;
- an upper-half write only passes with both keys valid;
- the mode and key registers capture exactly what was written.

The flat address arithmetic of each mode, the per-window ROM/RAM choice and the key sequences that lock and unlock protection are shown only by the bench. The bench sweeps addresses across all four modes under several bank settings and compares each output with values it computes itself.

// File: rtl/prg_xlate_pkg.sv
package prg_xlate_pkg;

    localparam int PG_W   = 7;   // 8 KB page number width
    localparam int OFF_W  = 13;  // offset inside an 8 KB page
    localparam int RSEL_W = 3;   // low RAM window page select
    localparam int NWIN   = 3;   // switchable ROM/RAM windows

    localparam logic [15:0] A_MODE = 16'h5100;
    localparam logic [15:0] A_KEYA = 16'h5102;
    localparam logic [15:0] A_KEYB = 16'h5103;
    localparam logic [15:0] A_RSEL = 16'h5113;
    localparam logic [15:0] A_WIN0 = 16'h5114;
    localparam logic [15:0] A_LAST = 16'h5117;

    localparam logic [7:0] KEYA_VAL = 8'h02;
    localparam logic [7:0] KEYB_VAL = 8'h01;

    typedef struct packed {
        logic [1:0]                  mode;
        logic                        key_a_ok;
        logic                        key_b_ok;
        logic [RSEL_W-1:0]           ram_sel;
        logic [NWIN-1:0]             win_rom;
        logic [NWIN-1:0][PG_W-1:0]   win_bank;
        logic [PG_W-1:0]             bank_last;
    } cfg_t;

    typedef struct packed {
        logic            hit;
        logic            is_ram;
        logic            fixed_ram;
        logic [PG_W-1:0] page;
    } map_t;

endpackage

// File: rtl/prg_cfg_regs.sv
module prg_cfg_regs
    import prg_xlate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output cfg_t        cfg_q
);

    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (addr == A_MODE) cfg_d.mode     = wdata[1:0];
            if (addr == A_KEYA) cfg_d.key_a_ok = (wdata == KEYA_VAL);
            if (addr == A_KEYB) cfg_d.key_b_ok = (wdata == KEYB_VAL);
            if (addr == A_RSEL) cfg_d.ram_sel  = wdata[RSEL_W-1:0];
            if (addr == A_LAST) cfg_d.bank_last = wdata[PG_W-1:0];
            for (int i = 0; i < NWIN; i++) begin
                if (addr == A_WIN0 + 16'(i)) begin
                    cfg_d.win_rom[i]  = wdata[7];
                    cfg_d.win_bank[i] = wdata[PG_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // R2: mode takes bits 1:0 of the written byte
    a_r2_mode_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MODE) |=> (cfg_q.mode == $past(wdata[1:0])));

    // R9: key A becomes valid only through a write of its unlock value
    a_r9_key_a_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_q.key_a_ok) |-> $past(wr_en && addr == A_KEYA && wdata == KEYA_VAL));

    // R9: key B becomes valid only through a write of its unlock value
    a_r9_key_b_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_q.key_b_ok) |-> $past(wr_en && addr == A_KEYB && wdata == KEYB_VAL));

endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
    import prg_xlate_pkg::*;
(
    input  cfg_t        cfg,
    input  logic [15:0] addr,
    output map_t        map
);

    logic [1:0] slot;
    assign slot = addr[14:13];

    always_comb begin
        map = '0;
        if (addr[15:13] == 3'b011) begin
            map.hit       = 1'b1;
            map.is_ram    = 1'b1;
            map.fixed_ram = 1'b1;
            map.page      = PG_W'(cfg.ram_sel);
        end else if (addr[15]) begin
            map.hit = 1'b1;
            unique case (cfg.mode)
                2'd0: map.page = {cfg.bank_last[PG_W-1:2], slot};
                2'd1: begin
                    if (!slot[1]) begin
                        map.is_ram = ~cfg.win_rom[1];
                        map.page   = {cfg.win_bank[1][PG_W-1:1], slot[0]};
                    end else begin
                        map.page   = {cfg.bank_last[PG_W-1:1], slot[0]};
                    end
                end
                2'd2: begin
                    if (!slot[1]) begin
                        map.is_ram = ~cfg.win_rom[1];
                        map.page   = {cfg.win_bank[1][PG_W-1:1], slot[0]};
                    end else if (!slot[0]) begin
                        map.is_ram = ~cfg.win_rom[2];
                        map.page   = cfg.win_bank[2];
                    end else begin
                        map.page   = cfg.bank_last;
                    end
                end
                default: begin
                    unique case (slot)
                        2'd0: begin
                            map.is_ram = ~cfg.win_rom[0];
                            map.page   = cfg.win_bank[0];
                        end
                        2'd1: begin
                            map.is_ram = ~cfg.win_rom[1];
                            map.page   = cfg.win_bank[1];
                        end
                        2'd2: begin
                            map.is_ram = ~cfg.win_rom[2];
                            map.page   = cfg.win_bank[2];
                        end
                        default: map.page = cfg.bank_last;
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/prg_bank_xlate.sv
module prg_bank_xlate
    import prg_xlate_pkg::*;
#(
    parameter int RAM_AW = 16,
    localparam int ROM_AW = PG_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_we,
    output logic              sel_ram,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              mem_we
);

    cfg_t        cfg_q;
    map_t        map;
    logic        unlocked;
    logic [ROM_AW-1:0] flat;

    prg_cfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cpu_we),
        .addr  (cpu_addr),
        .wdata (cpu_wdata),
        .cfg_q (cfg_q)
    );

    prg_window_map u_map (
        .cfg  (cfg_q),
        .addr (cpu_addr),
        .map  (map)
    );

    always_comb begin
        unlocked = cfg_q.key_a_ok & cfg_q.key_b_ok;
        flat     = map.hit ? {map.page, cpu_addr[OFF_W-1:0]} : '0;
        sel_ram  = map.is_ram;
        rom_addr = flat;
        ram_addr = flat[RAM_AW-1:0];
        mem_we   = cpu_we & map.is_ram & (map.fixed_ram | unlocked);
    end

    // R10: a memory write only ever targets RAM
    a_r10_we_needs_ram: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> sel_ram);

    // R10: the last 8 KB window is ROM in every mode
    a_r10_top_is_rom: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b111) |-> !sel_ram);

    // R4: mode 0 never places RAM in the upper half
    a_r4_mode0_rom: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == 2'd0 && cpu_addr[15]) |-> !sel_ram);

    // R3: the low window is always RAM
    a_r3_low_window_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b011) |-> sel_ram);

    // R9: upper-half writes pass only with both keys valid
    a_r9_locked_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && cpu_addr[15]) |-> (cfg_q.key_a_ok && cfg_q.key_b_ok));

    // R11: reads never write
    a_r11_read_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_we |-> !mem_we);

endmodule

// File: tb/prg_bank_xlate_tb_top.sv
module prg_bank_xlate_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int RAM_AW = 16;
    localparam int ROM_AW = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       cpu_addr = '0;
    logic [7:0]        cpu_wdata = '0;
    logic              cpu_we = 1'b0;
    logic              sel_ram;
    logic [ROM_AW-1:0] rom_addr;
    logic [RAM_AW-1:0] ram_addr;
    logic              mem_we;

    int checks = 0;
    int failures = 0;

    // bench model of the register contents
    logic [1:0] m_mode = '0;
    logic [7:0] m_win [3] = '{8'h00, 8'h00, 8'h00};
    logic [6:0] m_last = '0;
    logic [2:0] m_rsel = '0;
    logic [7:0] m_ka = '0;
    logic [7:0] m_kb = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prg_bank_xlate #(.RAM_AW(RAM_AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .sel_ram(sel_ram), .rom_addr(rom_addr),
        .ram_addr(ram_addr), .mem_we(mem_we)
    );

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
        case (a)
            16'h5100: m_mode = d[1:0];
            16'h5102: m_ka = d;
            16'h5103: m_kb = d;
            16'h5113: m_rsel = d[2:0];
            16'h5114: m_win[0] = d;
            16'h5115: m_win[1] = d;
            16'h5116: m_win[2] = d;
            16'h5117: m_last = d[6:0];
            default: ;
        endcase
    endtask

    // expected values from the requirements' arithmetic
    task automatic expect_at(input int a, input logic we, output logic e_sel,
                             output longint e_flat, output logic e_we);
        int w;
        logic is_ram;
        e_sel = 0; e_flat = 0; e_we = 0; is_ram = 0; w = -1;
        if (a < 'h6000) return;
        if (a < 'h8000) begin
            e_sel = 1; e_flat = m_rsel * 'h2000 + a % 'h2000; e_we = we;
            return;
        end
        case (m_mode)
            2'd0: e_flat = (m_last >> 2) * 'h8000 + a % 'h8000;
            2'd1: if (a < 'hC000) begin w = 1; e_flat = (m_win[1][6:0] >> 1) * 'h4000 + a % 'h4000; end
                  else e_flat = (m_last >> 1) * 'h4000 + a % 'h4000;
            2'd2: if (a < 'hC000) begin w = 1; e_flat = (m_win[1][6:0] >> 1) * 'h4000 + a % 'h4000; end
                  else if (a < 'hE000) begin w = 2; e_flat = m_win[2][6:0] * 'h2000 + a % 'h2000; end
                  else e_flat = m_last * 'h2000 + a % 'h2000;
            default: if (a < 'hE000) begin w = (a - 'h8000) / 'h2000; e_flat = m_win[w][6:0] * 'h2000 + a % 'h2000; end
                     else e_flat = m_last * 'h2000 + a % 'h2000;
        endcase
        if (w >= 0) is_ram = !m_win[w][7];   // R8: bit 7 = 1 means ROM
        e_sel = is_ram;
        e_we = we && is_ram && m_ka == 8'h02 && m_kb == 8'h01;
    endtask

    task automatic probe(input int a, input logic we, input string tag);
        logic e_sel, e_we;
        longint e_flat;
        logic [ROM_AW-1:0] e_rom;
        logic [RAM_AW-1:0] e_ram;
        @(negedge clk);
        cpu_addr = 16'(a); cpu_we = we;
        #1;
        expect_at(a, we, e_sel, e_flat, e_we);
        e_rom = ROM_AW'(e_flat);
        e_ram = RAM_AW'(e_flat);
        checks++;
        if ({sel_ram, mem_we, rom_addr, ram_addr} !== {e_sel, e_we, e_rom, e_ram}) begin
            failures++;
            $display("FAIL %s addr=%h we=%0d mode=%0d: sel/we/rom/ram got %0d/%0d/%h/%h exp %0d/%0d/%h/%h",
                     tag, a[15:0], we, m_mode, sel_ram, mem_we, rom_addr, ram_addr,
                     e_sel, e_we, e_rom, e_ram);
        end
        cpu_we = 1'b0;
    endtask

    function automatic string tag_for(input int a, input logic we);
        if (a < 'h6000) return "R11";
        if (a < 'h8000) return "R3";
        if (we) return "R9/R10";
        case (m_mode)
            2'd0: return "R4";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic load_cfg(input int c);
        case (c)
            0: begin wr(16'h5114, 8'h85); wr(16'h5115, 8'h0B); wr(16'h5116, 8'h93);
                     wr(16'h5117, 8'h7D); wr(16'h5113, 8'h05);
                     wr(16'h5102, 8'h02); wr(16'h5103, 8'h01); end
            1: begin wr(16'h5114, 8'h22); wr(16'h5115, 8'hCF); wr(16'h5116, 8'h07);
                     wr(16'h5117, 8'h2A); wr(16'h5113, 8'hFB);
                     wr(16'h5102, 8'h02); wr(16'h5103, 8'h00); end
            default: begin wr(16'h5114, 8'h7F); wr(16'h5115, 8'h80); wr(16'h5116, 8'hFF);
                     wr(16'h5117, 8'hFF); wr(16'h5113, 8'h0E);
                     wr(16'h5102, 8'h02); wr(16'h5103, 8'h01); end
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        probe('h9234, 1'b0, "R1");
        probe('hF00D, 1'b0, "R1");
        probe('h6ABC, 1'b0, "R1");
        probe('h6ABC, 1'b1, "R1");
        probe('h8100, 1'b1, "R1");
        probe('h5123, 1'b0, "R1");

        // R2: upper mode bits ignored; mode 2 selected by bits 1:0 of 0xFE
        load_cfg(0);
        wr(16'h5100, 8'hFE);
        probe('hC456, 1'b0, "R2");
        probe('hE456, 1'b0, "R2");

        // sweeps: every mode under three bank settings, reads and writes
        for (int c = 0; c < 3; c++) begin
            load_cfg(c);
            for (int m = 0; m < 4; m++) begin
                wr(16'h5100, 8'(8'hB4 | m));
                for (int a = 'h4000 + 37; a <= 'hFFFF; a += 'h233)
                    probe(a, 1'b0, tag_for(a, 1'b0));
                for (int a = 'h6000 + 11; a <= 'hFFFF; a += 'h233)
                    probe(a, 1'b1, tag_for(a, 1'b1));
            end
        end

        // R8: flipping bit 7 of a window register toggles ROM/RAM
        wr(16'h5100, 8'h03);
        wr(16'h5114, 8'h04);
        probe('h8010, 1'b0, "R8");
        wr(16'h5114, 8'h84);
        probe('h8010, 1'b0, "R8");

        // R9: key combinations, R3 stays writable throughout
        wr(16'h5114, 8'h04);
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: begin wr(16'h5102, 8'h02); wr(16'h5103, 8'h01); end
                1: begin wr(16'h5102, 8'h02); wr(16'h5103, 8'h00); end
                2: begin wr(16'h5102, 8'h00); wr(16'h5103, 8'h01); end
                3: begin wr(16'h5102, 8'h03); wr(16'h5103, 8'h01); end
                4: begin wr(16'h5102, 8'h02); wr(16'h5103, 8'h01); end
                default: wr(16'h5102, 8'h82);
            endcase
            probe('h8010, 1'b1, "R9");
            probe('h6010, 1'b1, "R3");
        end

        // R10: mode 0 ignores writes even when unlocked
        wr(16'h5102, 8'h02); wr(16'h5103, 8'h01);
        wr(16'h5100, 8'h00);
        probe('h8010, 1'b1, "R10");
        probe('hE010, 1'b1, "R10");

        // R12: RAM address keeps the low bits of a high bank
        wr(16'h5100, 8'h03);
        wr(16'h5116, 8'h7E);
        probe('hDFFF, 1'b0, "R12");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule